// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns data words into an asynchronous serial stream on one output line. Software-side logic pushes 8-bit or 9-bit words into a small first-in first-out queue. The shift stage takes them one at a time and frames each word with a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The bit period comes from a 16-bit divisor and an oversampling factor of 16 or 4. The line format is read from the configuration inputs when each frame starts, so it can change between characters.

Flow control can hold back the start of each new data frame until the active-low clear-to-send input is asserted. A break request sends a long low period, followed by a stop bit, ahead of any queued data. A loopback input steers the serial stream to a separate output for self-test, and keeps the external line idle. Two level outputs tell the host when the queue has room and when all transmission has finished.

Top module: `uart_tx_cfg`

## Requirements
- R1: After reset, tx_line and loop_line are high, tx_irq is 1, tx_done is 1 and full is 0.
- R2: Every bit, including the start bit, lasts exactly (cfg_div+1)*16 clocks when cfg_fast is 0 and (cfg_div+1)*4 clocks when cfg_fast is 1.
- R3: A frame is a low start bit, then the data bits least significant first, then the stop bits, which are high. The line is high between frames.
- R4: When cfg_nine is 0, cfg_par selects the parity bit sent after bit 7: 2'b01 is even (the ones in data plus parity make an even count), 2'b10 is odd, and 2'b00 or 2'b11 sends no parity bit.
- R5: When cfg_nine is 1, the frame carries wr_data[8:0] as nine data bits, and no parity bit is sent for any value of cfg_par.
- R6: cfg_two_stop=0 ends each frame with one stop bit, and cfg_two_stop=1 ends it with two.
- R7: The queue holds 4 words and sends them in write order. full is 1 while it holds 4 words, and a write while full is dropped and never sent.
- R8: While cfg_fc_en is 1 and cts_n is 1, no data frame starts. Queued words wait until cts_n goes to 0.
- R9: A one-cycle pulse on brk_req makes the line go low for exactly 13 bit periods, then high for one stop bit. A pending break starts before queued data and is not held back by cts_n.
- R10: tx_irq is 1 exactly when the queue has a free slot. tx_done is 1 only when no frame or break is in progress or pending and the queue is empty.
- R11: While loop_en is 1, the serial stream appears on loop_line and tx_line stays high. While loop_en is 0, loop_line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Baud divisor; the oversample tick period is cfg_div+1 clocks |
| cfg_fast | input | 1 | 1: 4 ticks per bit, 0: 16 ticks per bit |
| cfg_nine | input | 1 | 1: nine data bits per frame |
| cfg_par | input | 2 | Parity select: 01 even, 10 odd, 00/11 none |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_fc_en | input | 1 | Enables gating of data frames by cts_n |
| cts_n | input | 1 | Active-low clear to send |
| brk_req | input | 1 | Pulse to request a break |
| loop_en | input | 1 | Routes the serial stream to loop_line |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 9 | Word to queue |
| tx_line | output | 1 | Serial output line, idles high |
| loop_line | output | 1 | Loopback copy of the serial stream |
| tx_irq | output | 1 | Queue has a free slot |
| tx_done | output | 1 | All transmission complete |
| full | output | 1 | Queue holds 4 words |

## Verification
On every cycle, the assertions check several rules. The line changes only at a bit boundary or at a frame start. The oversample tick gap matches the divisor captured for the frame. The queue level never exceeds its depth and stays the same on a write while full. A data frame starts only when clear-to-send allows it. The external line stays high during loopback and whenever the block reports done. Only the bench scenarios show the frame contents: data bit order, the parity and stop bit choices, the exact low lengths of the start bit and the break, write order through the queue, and that a dropped word never reaches the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int BRK_BITS = 13;
  localparam int FRAME_W  = BRK_BITS + 1;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int OS_SLOW  = 16;
  localparam int OS_FAST  = 4;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_t;

  function automatic logic par_on(input par_t p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input par_t p);
    return (p == PAR_ODD) ? ~(^d) : (^d);
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic nine, input par_t p,
                                                 input logic two);
    int n;
    n = 1 + (nine ? 9 : 8) + ((!nine && par_on(p)) ? 1 : 0) + (two ? 2 : 1);
    return LEN_W'(n);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [8:0] d, input logic nine,
                                                     input par_t p);
    logic [FRAME_W-1:0] f;
    f    = '1;
    f[0] = 1'b0;
    if (nine) f[9:1] = d;
    else begin
      f[8:1] = d[7:0];
      if (par_on(p)) f[9] = par_bit(d[7:0], p);
    end
    return f;
  endfunction

  function automatic logic [FRAME_W-1:0] break_frame();
    logic [FRAME_W-1:0] f;
    f = '0;
    f[FRAME_W-1] = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             fast,
  output logic             os_tick,
  output logic             bit_end
);
  import uart_tx_pkg::*;

  localparam int OS_W = $clog2(OS_SLOW);

  logic [DIV_W-1:0] div_cnt;
  logic [OS_W-1:0]  os_cnt;
  logic [OS_W-1:0]  os_lim;

  assign os_lim  = fast ? OS_W'(OS_FAST - 1) : OS_W'(OS_SLOW - 1);
  assign os_tick = run && (div_cnt == div);
  assign bit_end = os_tick && (os_cnt == os_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      os_cnt  <= '0;
    end else if (!run) begin
      div_cnt <= '0;
      os_cnt  <= '0;
    end else if (os_tick) begin
      div_cnt <= '0;
      os_cnt  <= (os_cnt == os_lim) ? '0 : os_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign level   = count;
  assign head    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_end,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_fast,
  input  logic              cfg_nine,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_two_stop,
  input  logic              cfg_fc_en,
  input  logic              cts_n,
  input  logic              brk_req,
  output logic              pop,
  output logic              load_evt,
  output logic              active,
  output logic              brk_pend,
  output logic              ser_line,
  output logic [DIV_W-1:0]  cur_div,
  output logic              cur_fast
);
  import uart_tx_pkg::*;

  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   len, bit_cnt;
  logic               data_go;
  logic [8:0]         word;

  assign word     = 9'(q_head);
  assign data_go  = !active && !brk_pend && !q_empty && (!cfg_fc_en || !cts_n);
  assign pop      = data_go;
  assign load_evt = !active && (brk_pend || data_go);
  assign ser_line = active ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      brk_pend <= 1'b0;
      shreg    <= '1;
      len      <= '0;
      bit_cnt  <= '0;
      cur_div  <= '0;
      cur_fast <= 1'b0;
    end else begin
      if (brk_req) brk_pend <= 1'b1;
      if (load_evt) begin
        active   <= 1'b1;
        bit_cnt  <= '0;
        cur_div  <= cfg_div;
        cur_fast <= cfg_fast;
        if (brk_pend) begin
          shreg    <= break_frame();
          len      <= LEN_W'(FRAME_W);
          brk_pend <= 1'b0;
        end else begin
          shreg <= build_frame(word, cfg_nine, par_t'(cfg_par));
          len   <= frame_len(cfg_nine, par_t'(cfg_par), cfg_two_stop);
        end
      end else if (active && bit_end) begin
        if (bit_cnt == len - 1'b1) begin
          active <= 1'b0;
          shreg  <= '1;
        end else begin
          shreg   <= {1'b1, shreg[FRAME_W-1:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg #(
  parameter int DIV_W  = 16,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_fast,
  input  logic              cfg_nine,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_two_stop,
  input  logic              cfg_fc_en,
  input  logic              cts_n,
  input  logic              brk_req,
  input  logic              loop_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_line,
  output logic              loop_line,
  output logic              tx_irq,
  output logic              tx_done,
  output logic              full
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic              os_tick, bit_end;
  logic              pop, load_evt, active, brk_pend, ser_line;
  logic              fifo_empty;
  logic [DATA_W-1:0] fifo_head;
  logic [LVL_W-1:0]  fifo_level;
  logic [DIV_W-1:0]  cur_div;
  logic              cur_fast;

  uart_tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data), .pop(pop),
    .head(fifo_head), .empty(fifo_empty), .full(full), .level(fifo_level)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(active), .div(cur_div), .fast(cur_fast),
    .os_tick(os_tick), .bit_end(bit_end)
  );

  uart_tx_shift #(.DIV_W(DIV_W), .DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .q_empty(fifo_empty), .q_head(fifo_head),
    .cfg_div(cfg_div), .cfg_fast(cfg_fast), .cfg_nine(cfg_nine), .cfg_par(cfg_par),
    .cfg_two_stop(cfg_two_stop), .cfg_fc_en(cfg_fc_en), .cts_n(cts_n), .brk_req(brk_req),
    .pop(pop), .load_evt(load_evt), .active(active), .brk_pend(brk_pend),
    .ser_line(ser_line), .cur_div(cur_div), .cur_fast(cur_fast)
  );

  assign tx_line   = loop_en ? 1'b1 : ser_line;
  assign loop_line = loop_en ? ser_line : 1'b1;
  assign tx_irq    = !full;
  assign tx_done   = !active && !brk_pend && fifo_empty;
endmodule

// File: rtl/uart_tx_cfg_chk.sv
module uart_tx_cfg_chk #(
  parameter int DIV_W = 16,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ser_line,
  input logic                       active,
  input logic                       bit_end,
  input logic                       os_tick,
  input logic                       load_evt,
  input logic                       pop,
  input logic [DIV_W-1:0]           cur_div,
  input logic [$clog2(DEPTH+1)-1:0] fifo_level,
  input logic                       wr_en,
  input logic                       full,
  input logic                       cfg_fc_en,
  input logic                       cts_n,
  input logic                       loop_en,
  input logic                       tx_line,
  input logic                       loop_line,
  input logic                       tx_done
);
  logic [DIV_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap <= '0;
    else if (!active || os_tick) gap <= '0;
    else                        gap <= gap + 1'b1;
  end

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> ser_line);

  // R2
  edge_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_line != $past(ser_line)) |-> ($past(bit_end) || $past(load_evt)));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> (gap == cur_div));

  // R7
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !pop) |=> (fifo_level == $past(fifo_level)));

  // R8
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (!cfg_fc_en || !cts_n));

  // R11
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> tx_line);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (tx_line && loop_line));
endmodule

bind uart_tx_cfg uart_tx_cfg_chk #(.DIV_W(DIV_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ser_line(ser_line), .active(active), .bit_end(bit_end),
  .os_tick(os_tick), .load_evt(load_evt), .pop(pop), .cur_div(cur_div),
  .fifo_level(fifo_level), .wr_en(wr_en), .full(full), .cfg_fc_en(cfg_fc_en),
  .cts_n(cts_n), .loop_en(loop_en), .tx_line(tx_line), .loop_line(loop_line),
  .tx_done(tx_done)
);

// File: tb/uart_tx_cfg_tb.sv
`timescale 1ns/1ps
module uart_tx_cfg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = '0;
  logic        cfg_fast = 1'b0, cfg_nine = 1'b0, cfg_two_stop = 1'b0;
  logic [1:0]  cfg_par = 2'b00;
  logic        cfg_fc_en = 1'b0, cts_n = 1'b1, brk_req = 1'b0, loop_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_data = '0;
  logic        tx_line, loop_line, tx_irq, tx_done, full;

  int checks = 0;
  int fails  = 0;
  int tx_low_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_tx_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fast(cfg_fast), .cfg_nine(cfg_nine),
    .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .cfg_fc_en(cfg_fc_en), .cts_n(cts_n),
    .brk_req(brk_req), .loop_en(loop_en), .wr_en(wr_en), .wr_data(wr_data),
    .tx_line(tx_line), .loop_line(loop_line), .tx_irq(tx_irq), .tx_done(tx_done), .full(full)
  );

  always @(negedge clk) if (!tx_line) tx_low_cnt++;

  function automatic int period_of(input logic [15:0] d, input logic f);
    return (int'(d) + 1) * (f ? 4 : 16);
  endfunction

  function automatic int bits_of(input logic nine, input logic [1:0] p, input logic two);
    int n;
    n = nine ? 10 : 9;
    if (!nine && (p == 2'b01 || p == 2'b10)) n++;
    return n + (two ? 2 : 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [15:0] d, input logic f, input logic nine,
                         input logic [1:0] p, input logic two);
    cfg_div = d; cfg_fast = f; cfg_nine = nine; cfg_par = p; cfg_two_stop = two;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!tx_done);
  endtask

  function automatic logic pick(input bit lp);
    return lp ? loop_line : tx_line;
  endfunction

  // Decodes one frame by mid-bit sampling and compares with a bit list built here.
  task automatic decode(input bit lp, input logic [8:0] w, input string req);
    logic exp_bits [14];
    int n, p, bad, got;
    logic ones;
    p = period_of(cfg_div, cfg_fast);
    n = bits_of(cfg_nine, cfg_par, cfg_two_stop);
    for (int i = 0; i < 14; i++) exp_bits[i] = 1'b1;
    exp_bits[0] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < (cfg_nine ? 9 : 8); i++) begin
      exp_bits[1+i] = w[i];
      ones ^= w[i];
    end
    if (!cfg_nine && cfg_par == 2'b01) exp_bits[9] = ones;
    if (!cfg_nine && cfg_par == 2'b10) exp_bits[9] = ~ones;
    do @(negedge clk); while (pick(lp));
    bad = 0; got = 0;
    repeat (p/2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (i > 0) repeat (p) @(negedge clk);
      got |= int'(pick(lp)) << i;
      if (pick(lp) !== exp_bits[i]) bad++;
    end
    begin
      int e = 0;
      for (int i = 0; i < n; i++) e |= int'(exp_bits[i]) << i;
      check(bad == 0, req, got, e);
    end
  endtask

  task automatic measure_low(output int len);
    do @(negedge clk); while (tx_line);
    len = 1;
    forever begin
      @(negedge clk);
      if (tx_line) break;
      len++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int len;
    logic [8:0] q [4];
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_line == 1'b1 && loop_line == 1'b1, "R1 lines", {tx_line, loop_line}, 3);
    check(tx_irq == 1'b1 && tx_done == 1'b1 && full == 1'b0, "R1 flags",
          {tx_irq, tx_done, full}, 6);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 start bit length, 16x and 4x
    set_cfg(16'd1, 1'b0, 1'b0, 2'b00, 1'b0);
    push(9'h001);
    measure_low(len);
    check(len == period_of(16'd1, 1'b0), "R2 16x start", len, period_of(16'd1, 1'b0));
    wait_idle();
    set_cfg(16'd2, 1'b1, 1'b0, 2'b00, 1'b0);
    push(9'h0F1);
    measure_low(len);
    check(len == period_of(16'd2, 1'b1), "R2 4x start", len, period_of(16'd2, 1'b1));
    wait_idle();

    // R3 plain frames and R7 order through the queue
    set_cfg(16'd0, 1'b1, 1'b0, 2'b00, 1'b0);
    for (int i = 0; i < 4; i++) q[i] = 9'($urandom_range(0, 255));
    fork
      for (int i = 0; i < 4; i++) push(q[i]);
      for (int i = 0; i < 4; i++) decode(1'b0, q[i], "R3 R7 order");
    join
    wait_idle();

    // R4 even and odd parity, R6 two stops
    set_cfg(16'd1, 1'b1, 1'b0, 2'b01, 1'b1);
    fork push(9'h0B7); decode(1'b0, 9'h0B7, "R4 even R6"); join
    wait_idle();
    set_cfg(16'd1, 1'b1, 1'b0, 2'b10, 1'b0);
    fork push(9'h0B7); decode(1'b0, 9'h0B7, "R4 odd"); join
    wait_idle();
    set_cfg(16'd1, 1'b1, 1'b0, 2'b11, 1'b1);
    fork push(9'h033); decode(1'b0, 9'h033, "R4 none R6"); join
    wait_idle();

    // R5 nine bits with parity selected (even parity of data would be 0)
    set_cfg(16'd0, 1'b1, 1'b1, 2'b01, 1'b0);
    fork push(9'h1C3); decode(1'b0, 9'h1C3, "R5 nine"); join
    wait_idle();

    // R7 R8 R10 full queue held by flow control
    set_cfg(16'd0, 1'b1, 1'b0, 2'b00, 1'b0);
    cfg_fc_en = 1'b1; cts_n = 1'b1; tx_low_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      q[i] = 9'($urandom_range(0, 255));
      push(q[i]);
    end
    check(full == 1'b1 && tx_irq == 1'b0, "R7 R10 full", {full, tx_irq}, 2);
    push(9'h0AA);
    repeat (100) @(negedge clk);
    check(tx_low_cnt == 0, "R8 held", tx_low_cnt, 0);
    check(tx_done == 1'b0, "R10 not done", tx_done, 0);
    cts_n = 1'b0;
    for (int i = 0; i < 4; i++) decode(1'b0, q[i], "R7 R8 release");
    wait_idle();
    tx_low_cnt = 0;
    repeat (3 * 12 * period_of(16'd0, 1'b1)) @(negedge clk);
    check(tx_low_cnt == 0, "R7 dropped", tx_low_cnt, 0);
    check(tx_irq == 1'b1 && tx_done == 1'b1, "R10 idle", {tx_irq, tx_done}, 3);

    // R9 break, not gated by cts_n
    cts_n = 1'b1;
    set_cfg(16'd1, 1'b1, 1'b0, 2'b00, 1'b0);
    @(negedge clk); brk_req = 1'b1;
    @(negedge clk); brk_req = 1'b0;
    measure_low(len);
    check(len == 13 * period_of(16'd1, 1'b1), "R9 break", len, 13 * period_of(16'd1, 1'b1));
    wait_idle();
    cfg_fc_en = 1'b0;

    // R11 loopback
    loop_en = 1'b1; tx_low_cnt = 0;
    fork push(9'h03C); decode(1'b1, 9'h03C, "R11 loop"); join
    wait_idle();
    check(tx_low_cnt == 0, "R11 tx held", tx_low_cnt, 0);
    loop_en = 1'b0;

    // Random formats
    for (int k = 0; k < 10; k++) begin
      set_cfg(16'($urandom_range(0, 2)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      for (int i = 0; i < 3; i++) q[i] = 9'($urandom_range(0, 511));
      fork
        for (int i = 0; i < 3; i++) push(q[i]);
        for (int i = 0; i < 3; i++) decode(1'b0, q[i], "R3 R4 R5 R6 random");
      join
      wait_idle();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule